// File: doc/BRIEF.md
# I2C bus monitor

This block watches the two wires of an I2C bus without ever driving them. It takes SCL and SDA as levels that have already been brought into the system clock domain, compares each cycle's levels with those of the cycle before, and reports what it sees on the bus as a stream of single-cycle events: START, repeated START, STOP, acknowledge or not-acknowledge, and every received byte.

Each byte event is labelled as an address or a data byte, and as read or write. The direction comes from the last address byte. An address event carries the 7-bit address with the direction bit removed. A data event carries the whole byte. Both also show the raw byte as it arrived. A logic analyser front end, a debug trace buffer or a protocol checker can consume the event stream directly.

Top module: `i2c_bus_monitor`

## Requirements
- R1: When the monitor is idle, SDA going from 1 to 0 while SCL is high is a START. The cycle after that sample, `evt_valid` is 1 and `evt_code` is 0.
- R2: While the monitor waits between bytes, SDA going from 0 to 1 while SCL is high is a STOP (`evt_code` 2). The monitor returns to idle and clears the direction and the repeated-start flag, so the next START is reported with code 0.
- R3: Bits are taken on SCL rising edges, most significant bit first. The cycle after the eighth rising edge, a byte event appears with the assembled byte on `evt_raw`.
- R4: The first byte after any START is an address. Its bit 0 is the direction (1 read, 0 write). The event code is 5 for read and 6 for write, `evt_value` is the byte shifted right by one, and `evt_rw` equals bit 0.
- R5: Later bytes are data. `evt_value` equals `evt_raw`, the whole byte. The code is 7 when the last address byte was a read and 8 when it was a write, and `evt_rw` follows the same direction.
- R6: The SCL rising edge after a byte is the acknowledge bit. SDA low gives code 3 (ACK) and SDA high gives code 4 (NACK). The monitor then waits for data, START or STOP.
- R7: A START seen while waiting between bytes, with no STOP since the last START, is reported as a repeated START (code 1). It clears any partly collected bits, and the next byte is an address.
- R8: Levels on SDA that form a START or STOP while an address byte or an acknowledge bit is in progress produce no event and do not disturb the bits being collected.
- R9: The first sample after reset only loads the stored previous levels. No event comes from it, even when SCL is high and SDA is low.
- R10: `evt_valid` is high for exactly one cycle per decoded item. While it is low, `evt_code`, `evt_value`, `evt_rw` and `evt_raw` are all 0.
- R11: A synchronous reset clears every output, returns the monitor to idle, and drops the partly collected byte, the direction and the repeated-start flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| evt_valid | output | 1 | One-cycle strobe for a decoded item |
| evt_code | output | 4 | Kind of item (0..8, see R1, R2, R4 to R7) |
| evt_value | output | BYTE_BITS | Address with direction removed, or the whole data byte |
| evt_rw | output | 1 | Direction for byte events: 1 read, 0 write |
| evt_raw | output | BYTE_BITS | Byte exactly as received |

## Verification
The bench builds the monitor with the default byte width of eight. At that width, real bus addresses and data bytes, the direction bit and the acknowledge slot line up as they do on a real bus. Each SCL and SDA step is held for a few system cycles, so rising edges and START/STOP patterns land on separate samples. The bench also places patterns inside the high phase of SCL, during an address byte and right after the eighth bit, so that the rules for ignoring START and STOP can be seen. Its resets fall before the first sample and in the middle of a byte.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int EVT_W = 4;

  // Event codes seen on evt_code
  typedef enum logic [EVT_W-1:0] {
    EV_START   = 4'd0,
    EV_RSTART  = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_ADDR_RD = 4'd5,
    EV_ADDR_WR = 4'd6,
    EV_DATA_RD = 4'd7,
    EV_DATA_WR = 4'd8
  } mon_evt_e;

  // Decoder phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACK  = 2'd2,
    PH_DATA = 2'd3
  } mon_phase_e;

endpackage

// File: rtl/i2c_mon_edges.sv
// Previous-level registers and the three bus conditions derived from them.
module i2c_mon_edges (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic armed_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o
);

  logic scl_q;
  logic sda_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      armed_q <= 1'b1;
    end
  end

  // Nothing is evaluated until one real sample has been stored.
  assign armed_o = armed_q;
  assign start_o = armed_q & sda_q & ~sda_i & scl_i;
  assign stop_o  = armed_q & ~sda_q & sda_i & scl_i;
  assign rise_o  = armed_q & ~scl_q & scl_i;

endmodule

// File: rtl/i2c_mon_shift.sv
// MSB-first byte collector with its bit counter.
module i2c_mon_shift #(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 take_i,
  input  logic                 bit_i,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 last_o
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_BITS - 1);

  logic [BYTE_BITS-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;

  // Byte as it stands once the current bit has been shifted in.
  assign byte_o = {sh_q[BYTE_BITS-2:0], bit_i};
  assign last_o = (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      if (last_o) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else begin
        sh_q  <= byte_o;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_mon_fsm.sv
// Phase controller: decides which condition counts and builds the event.
module i2c_mon_fsm
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rise_i,
  input  logic                 sda_i,
  input  logic                 byte_last_i,
  input  logic [BYTE_BITS-1:0] byte_i,
  output logic                 take_o,
  output logic                 clr_o,
  output mon_phase_e           phase_o,
  output logic                 evt_valid_o,
  output logic [EVT_W-1:0]     evt_code_o,
  output logic [BYTE_BITS-1:0] evt_value_o,
  output logic                 evt_rw_o,
  output logic [BYTE_BITS-1:0] evt_raw_o
);

  function automatic logic [BYTE_BITS-1:0] addr_of(input logic [BYTE_BITS-1:0] b);
    return b >> 1;
  endfunction

  function automatic mon_evt_e byte_kind(input logic is_addr, input logic rd);
    if (is_addr) return rd ? EV_ADDR_RD : EV_ADDR_WR;
    return rd ? EV_DATA_RD : EV_DATA_WR;
  endfunction

  mon_phase_e           phase_q, phase_n;
  logic                 rep_q, rep_n;
  logic                 dir_q, dir_n;
  logic                 fire;
  mon_evt_e             code_n;
  logic [BYTE_BITS-1:0] val_n;
  logic [BYTE_BITS-1:0] raw_n;
  logic                 rw_n;

  assign phase_o = phase_q;

  always_comb begin
    take_o  = 1'b0;
    clr_o   = 1'b0;
    fire    = 1'b0;
    code_n  = EV_START;
    val_n   = '0;
    raw_n   = '0;
    rw_n    = 1'b0;
    phase_n = phase_q;
    rep_n   = rep_q;
    dir_n   = dir_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          fire    = 1'b1;
          code_n  = rep_q ? EV_RSTART : EV_START;
          clr_o   = 1'b1;
          phase_n = PH_ADDR;
          rep_n   = 1'b1;
          dir_n   = 1'b0;
        end
      end
      PH_ADDR: begin
        if (rise_i) begin
          take_o = 1'b1;
          if (byte_last_i) begin
            fire    = 1'b1;
            code_n  = byte_kind(1'b1, byte_i[0]);
            val_n   = addr_of(byte_i);
            raw_n   = byte_i;
            rw_n    = byte_i[0];
            dir_n   = byte_i[0];
            phase_n = PH_ACK;
          end
        end
      end
      PH_ACK: begin
        if (rise_i) begin
          fire    = 1'b1;
          code_n  = sda_i ? EV_NACK : EV_ACK;
          phase_n = PH_DATA;
        end
      end
      PH_DATA: begin
        if (rise_i) begin
          take_o = 1'b1;
          if (byte_last_i) begin
            fire    = 1'b1;
            code_n  = byte_kind(1'b0, dir_q);
            val_n   = byte_i;
            raw_n   = byte_i;
            rw_n    = dir_q;
            phase_n = PH_ACK;
          end
        end else if (start_i) begin
          fire    = 1'b1;
          code_n  = rep_q ? EV_RSTART : EV_START;
          clr_o   = 1'b1;
          phase_n = PH_ADDR;
          rep_n   = 1'b1;
          dir_n   = 1'b0;
        end else if (stop_i) begin
          fire    = 1'b1;
          code_n  = EV_STOP;
          phase_n = PH_IDLE;
          rep_n   = 1'b0;
          dir_n   = 1'b0;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      rep_q       <= 1'b0;
      dir_q       <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_code_o  <= '0;
      evt_value_o <= '0;
      evt_rw_o    <= 1'b0;
      evt_raw_o   <= '0;
    end else begin
      phase_q     <= phase_n;
      rep_q       <= rep_n;
      dir_q       <= dir_n;
      evt_valid_o <= fire;
      evt_code_o  <= code_n;
      evt_value_o <= val_n;
      evt_rw_o    <= rw_n;
      evt_raw_o   <= raw_n;
    end
  end

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 evt_valid,
  output logic [EVT_W-1:0]     evt_code,
  output logic [BYTE_BITS-1:0] evt_value,
  output logic                 evt_rw,
  output logic [BYTE_BITS-1:0] evt_raw
);

  // Internal events, named for the checker
  logic                 armed;
  logic                 start_cond;
  logic                 stop_cond;
  logic                 scl_rise;
  logic                 take_bit;
  logic                 clr_bits;
  logic                 byte_last;
  logic [BYTE_BITS-1:0] byte_now;
  mon_phase_e           phase;

  i2c_mon_edges u_edges (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .armed_o (armed),
    .start_o (start_cond),
    .stop_o  (stop_cond),
    .rise_o  (scl_rise)
  );

  i2c_mon_shift #(.BYTE_BITS(BYTE_BITS)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_bits),
    .take_i (take_bit),
    .bit_i  (sda_i),
    .byte_o (byte_now),
    .last_o (byte_last)
  );

  i2c_mon_fsm #(.BYTE_BITS(BYTE_BITS)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_cond),
    .stop_i      (stop_cond),
    .rise_i      (scl_rise),
    .sda_i       (sda_i),
    .byte_last_i (byte_last),
    .byte_i      (byte_now),
    .take_o      (take_bit),
    .clr_o       (clr_bits),
    .phase_o     (phase),
    .evt_valid_o (evt_valid),
    .evt_code_o  (evt_code),
    .evt_value_o (evt_value),
    .evt_rw_o    (evt_rw),
    .evt_raw_o   (evt_raw)
  );

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 armed,
  input logic                 start_cond,
  input mon_phase_e           phase,
  input logic                 evt_valid,
  input logic [EVT_W-1:0]     evt_code,
  input logic [BYTE_BITS-1:0] evt_value,
  input logic                 evt_rw,
  input logic [BYTE_BITS-1:0] evt_raw
);

  p_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start_cond) |=> (evt_valid && evt_code == EV_START));

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_STOP) |-> (phase == PH_IDLE));

  p_addr_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_ADDR_RD) |-> (evt_rw && evt_value == (evt_raw >> 1)));

  p_addr_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_ADDR_WR) |-> (!evt_rw && evt_value == (evt_raw >> 1)));

  p_data_whole_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_code == EV_DATA_RD || evt_code == EV_DATA_WR)) |-> (evt_value == evt_raw));

  p_data_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_DATA_RD) |-> evt_rw);

  p_quiet_in_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR) |=> !(evt_valid &&
      (evt_code == EV_START || evt_code == EV_RSTART || evt_code == EV_STOP)));

  p_first_sample_r9: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !evt_valid);

  p_idle_payload_r10: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |-> (evt_code == '0 && evt_value == '0 && !evt_rw && evt_raw == '0));

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk #(.BYTE_BITS(BYTE_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .armed      (armed),
  .start_cond (start_cond),
  .phase      (phase),
  .evt_valid  (evt_valid),
  .evt_code   (evt_code),
  .evt_value  (evt_value),
  .evt_rw     (evt_rw),
  .evt_raw    (evt_raw)
);

// File: tb/i2c_bus_monitor_test.sv
module i2c_bus_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 8;
  localparam int HOLD       = 3;
  localparam int WD_CYCLES  = 50000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl = 1'b1;
  logic          sda = 1'b0;
  logic          evt_valid;
  logic [3:0]    evt_code;
  logic [NB-1:0] evt_value;
  logic          evt_rw;
  logic [NB-1:0] evt_raw;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R9";
  int seen[$];

  i2c_bus_monitor #(.BYTE_BITS(NB)) uut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl),
    .sda_i     (sda),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_value (evt_value),
    .evt_rw    (evt_rw),
    .evt_raw   (evt_raw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: phase 0 idle, 1 address, 2 ack, 3 data
  int m_phase, m_nb, m_acc, m_dir, m_rep, m_primed, m_pscl, m_psda;
  int e_v, e_c, e_val, e_rw, e_raw;
  int x_v = 0, x_c = 0, x_val = 0, x_rw = 0, x_raw = 0;
  int started = 0;
  bit rise, stc, spc;

  always @(posedge clk) begin
    e_v = 0; e_c = 0; e_val = 0; e_rw = 0; e_raw = 0;
    if (rst) begin
      m_phase = 0; m_nb = 0; m_acc = 0; m_dir = 0; m_rep = 0;
      m_primed = 0; m_pscl = 1; m_psda = 1;
    end else if (m_primed == 0) begin
      m_primed = 1; m_pscl = int'(scl); m_psda = int'(sda);
    end else begin
      rise = (m_pscl == 0) && scl;
      stc  = (m_psda == 1) && !sda && scl;
      spc  = (m_psda == 0) && sda && scl;
      if ((m_phase == 1 || m_phase == 3) && rise) begin
        m_acc = ((m_acc * 2) + int'(sda)) % 256;
        m_nb++;
        if (m_nb == 8) begin
          e_v = 1; e_raw = m_acc;
          if (m_phase == 1) begin
            m_dir = m_acc % 2;
            e_c = (m_dir == 1) ? 5 : 6;
            e_val = m_acc / 2;
          end else begin
            e_c = (m_dir == 1) ? 7 : 8;
            e_val = m_acc;
          end
          e_rw = m_dir;
          m_nb = 0; m_acc = 0; m_phase = 2;
        end
      end else if (m_phase == 2) begin
        if (rise) begin
          e_v = 1; e_c = sda ? 4 : 3; m_phase = 3;
        end
      end else if ((m_phase == 0 || m_phase == 3) && stc) begin
        e_v = 1; e_c = (m_rep == 1) ? 1 : 0;
        m_rep = 1; m_dir = 0; m_nb = 0; m_acc = 0; m_phase = 1;
      end else if (m_phase == 3 && spc) begin
        e_v = 1; e_c = 2; m_rep = 0; m_dir = 0; m_phase = 0;
      end
      m_pscl = int'(scl); m_psda = int'(sda);
    end
    x_v <= e_v; x_c <= e_c; x_val <= e_val; x_rw <= e_rw; x_raw <= e_raw;
    started <= 1;
  end

  function automatic string tag_of(int code);
    case (code)
      0: return "R1";
      1: return "R7";
      2: return "R2";
      3, 4: return "R6";
      5, 6: return "R3,R4";
      default: return "R3,R5";
    endcase
  endfunction

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started == 1) begin
      string t;
      if (rst) t = "R11";
      else if (x_v == 0) t = cur_tag;
      else t = tag_of(x_c);
      checks++;
      if (evt_valid !== 1'(x_v) || evt_code !== 4'(x_c) || evt_value !== NB'(x_val) ||
          evt_rw !== 1'(x_rw) || evt_raw !== NB'(x_raw)) begin
        errors++;
        $display("FAIL %s t=%0t: actual v=%0b code=%0d value=%h rw=%0b raw=%h expected v=%0d code=%0d value=%h rw=%0d raw=%h",
                 t, $time, evt_valid, evt_code, evt_value, evt_rw, evt_raw,
                 x_v, x_c, x_val, x_rw, x_raw);
      end
      if (evt_valid === 1'b1) seen.push_back(int'(evt_code));
    end
  end

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl == 1'b0) begin
      sda = 1'b1; hold();
      scl = 1'b1; hold();
    end
    sda = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic bus_bit(input bit b);
    sda = b;    hold();
    scl = 1'b1; hold();
    scl = 1'b0; hold();
  endtask

  task automatic bus_byte(input logic [7:0] b, input bit ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(ack);
  endtask

  task automatic bus_stop();
    sda = 1'b0; hold();
    scl = 1'b1; hold();
    sda = 1'b1; hold();
  endtask

  initial begin
    // R9 and R11: reset with SCL high and SDA low, release, no event expected
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    sda = 1'b1; hold();
    cur_tag = "R10";

    // Write transaction: address 0x50 write, data 0x3C, NACK, STOP
    seen.delete();
    bus_start();
    bus_byte(8'hA0, 1'b0);
    bus_byte(8'h3C, 1'b1);
    bus_stop();
    hold();
    begin
      int exp_seq[6] = '{0, 6, 3, 8, 4, 2};
      checks++;
      if (seen.size() != 6) begin
        errors++;
        $display("FAIL R10 event count: actual %0d expected 6", seen.size());
      end else begin
        for (int i = 0; i < 6; i++) begin
          checks++;
          if (seen[i] != exp_seq[i]) begin
            errors++;
            $display("FAIL %s event %0d: actual code %0d expected %0d",
                     tag_of(exp_seq[i]), i, seen[i], exp_seq[i]);
          end
        end
      end
    end

    // R7: read of 0x50 with two data bytes, repeated START, write of 0x21
    bus_start();
    bus_byte(8'hA1, 1'b0);
    bus_byte(8'hFF, 1'b0);
    bus_byte(8'h00, 1'b1);
    bus_start();
    bus_byte(8'h42, 1'b0);
    bus_byte(8'h81, 1'b0);
    bus_stop();
    hold();

    // R8: START and STOP patterns inside an address bit and after the 8th bit
    cur_tag = "R8";
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    sda = 1'b1; hold(); scl = 1'b1; hold();
    sda = 1'b0; hold(); sda = 1'b1; hold();
    scl = 1'b0; hold();
    bus_bit(1'b0); bus_bit(1'b0); bus_bit(1'b1);
    sda = 1'b0; hold(); scl = 1'b1; hold();
    sda = 1'b1; hold(); sda = 1'b0; hold();
    scl = 1'b0; hold();
    bus_bit(1'b0);
    bus_byte(8'h5A, 1'b0);
    // R2: STOP in the middle of a data byte, then a fresh plain START
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
    bus_stop();
    hold();
    cur_tag = "R2";
    bus_start();
    bus_byte(8'h43, 1'b0);
    bus_byte(8'hC3, 1'b1);
    bus_stop();
    hold();

    // R11: reset in the middle of an address byte
    cur_tag = "R11";
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b0); bus_bit(1'b1);
    @(negedge clk);
    rst = 1'b1; scl = 1'b1; sda = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    hold();
    bus_start();
    bus_byte(8'h90, 1'b0);
    bus_byte(8'h17, 1'b0);
    bus_stop();
    hold();
    repeat (4) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual cycles=%0d expected fewer", WD_CYCLES);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule